// File: doc/BRIEF.md
# Address-Generation Interlock Issue Controller

This block decides, cycle by cycle, whether the instruction sitting in decode may move into address generation in a single-issue, in-order pipeline. The pipeline has six stages in a fixed order: decode, address generation, two cache cycles, execute and write-back. Because addresses are formed right after decode, a register that an instruction reads as an address base or index must have been produced some cycles earlier. How many cycles depends on the class of the producing instruction. A general integer or memory result needs five cycles. A load result arrives over a bypass in three. A load-address result takes a shorter bypass and needs two.

Instructions are handled only as tokens. Each token carries a class code, a call flag, a destination register, base and index registers and a tag. A per-register countdown scoreboard records when each register becomes usable for address formation. Separately, a counter on the execute stage holds the front of the pipeline while a multi-cycle instruction occupies execute. The stage valids and tags come out as a view for observation.

Top module: `agi_issue_ctrl`

## Requirements
- R1: A synchronous active-high reset empties every stage (all `stg_vld` bits 0) and clears the scoreboard, so an address-forming instruction presented right after reset issues at once.
- R2: An instruction that issues in cycle t shows its tag in the address-generation stage (index 0) in cycle t+1. It then moves one stage per cycle through cache 1 (index 1), cache 2 (index 2), execute (index 3) and write-back (index 4), as long as no multi-cycle instruction holds execute. The tag of stage i sits in `stg_tag[i*TW +: TW]`.
- R3: A result from class 0 (integer) or class 1 (memory) can be used as an address register only by an instruction that issues at least 5 cycles after the producer. Presented one cycle after the producer, such a consumer stalls 4 cycles.
- R4: A result from class 2 (load) needs a gap of 3 cycles, which gives 2 stall cycles when the consumer follows directly.
- R5: A result from class 4 (load address) or class 5 (relative load address) needs a gap of 2 cycles, which gives 1 stall cycle when the consumer follows directly.
- R6: Only class 1 (memory), class 2 (load), class 4 (load address) and any instruction with `in_call` set form an address. For classes 0, 3, 5, 6 and 7 without `in_call`, the base and index fields never cause a stall.
- R7: Register 0 as base or index means "no register" and never stalls. A producer whose destination is register 0 records nothing.
- R8: Class 3 (store), class 6 (two-cycle op), class 7 (three-cycle op) and call instructions record no scoreboard entry. Their destination causes no address stall.
- R9: When a register is written again before its count expires, only the latest producer's gap applies, whether it is shorter or longer.
- R10: Class 6 holds execute for 2 cycles, class 7 for 3 cycles and a call for 5 cycles. During each extra cycle the address-generation and cache stages hold, write-back receives a bubble, and a valid instruction in decode stalls.
- R11: `stall` is high exactly when `in_valid` is high and the instruction cannot issue. `issue` and `stall` are never high together. A stalled instruction is kept and issues later with its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor in decode is valid |
| in_cls | input | 3 | Class code (0 int, 1 mem, 2 load, 3 store, 4 la, 5 rel-la, 6 two-cycle, 7 three-cycle) |
| in_call | input | 1 | Instruction is a call (class field then ignored) |
| in_dst | input | 4 | Destination register |
| in_base | input | 4 | Address base register (0 = none) |
| in_idx | input | 4 | Address index register (0 = none) |
| in_tag | input | 4 | Token tag carried down the pipeline |
| issue | output | 1 | Decode instruction enters address generation this cycle |
| stall | output | 1 | Decode instruction is held this cycle |
| stg_vld | output | 5 | Valid per stage: agen, cache1, cache2, execute, write-back |
| stg_tag | output | 20 | Tag per stage, stage i at bits i*4 +: 4 |

## Verification
The checker assumes that the decode descriptor stays unchanged while `stall` is high, and that `in_valid` is low during reset. The property tying an issued tag to the address-generation stage depends on both. The bench drives every instruction through one task that keeps all fields steady until `issue` is seen, then drops `in_valid` at the next falling edge. The tests are separated by idle gaps long enough to drain the longest execute hold, so no count or hold carries over from one scenario into the next.

// File: rtl/agi_issue_ctrl.sv
`timescale 1ns/1ps
module agi_issue_ctrl #(
  parameter int NREG     = 16,
  parameter int TW       = 4,
  parameter int GAP_ALU  = 5,
  parameter int GAP_LD   = 3,
  parameter int GAP_LA   = 2,
  parameter int OCC_O2   = 2,
  parameter int OCC_O3   = 3,
  parameter int OCC_CALL = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [2:0]            in_cls,
  input  logic                  in_call,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_base,
  input  logic [$clog2(NREG)-1:0] in_idx,
  input  logic [TW-1:0]         in_tag,
  output logic                  issue,
  output logic                  stall,
  output logic [4:0]            stg_vld,
  output logic [5*TW-1:0]       stg_tag
);
  localparam int RW   = $clog2(NREG);
  localparam int NST  = 5;
  localparam int GMAX = (GAP_ALU > GAP_LD) ? ((GAP_ALU > GAP_LA) ? GAP_ALU : GAP_LA)
                                           : ((GAP_LD > GAP_LA) ? GAP_LD : GAP_LA);
  localparam int OM1  = (OCC_O2 > OCC_O3) ? OCC_O2 : OCC_O3;
  localparam int OMAX = (OM1 > OCC_CALL) ? OM1 : OCC_CALL;
  localparam int CW   = $clog2(GMAX) < 1 ? 1 : $clog2(GMAX);
  localparam int EW   = $clog2(OMAX) < 1 ? 1 : $clog2(OMAX);

  logic [NST-1:0]           vld;
  logic [NST-1:0][TW-1:0]   tag;
  logic [NST-1:0][2:0]      cls;
  logic [NST-1:0]           isc;
  logic [EW-1:0]            ex_left;
  logic [NREG-1:0][CW-1:0]  sb_cnt;

  logic addr_use, hazard, freeze;
  logic [CW:0] gap;

  function automatic logic busy(input logic [RW-1:0] r, input logic [NREG-1:0][CW-1:0] cnt);
    return (r != '0) && (cnt[r] != '0);
  endfunction

  function automatic logic [EW:0] occ(input logic [2:0] c, input logic k);
    if (k)            return (EW+1)'(OCC_CALL);
    else if (c == 3'd6) return (EW+1)'(OCC_O2);
    else if (c == 3'd7) return (EW+1)'(OCC_O3);
    else              return (EW+1)'(1);
  endfunction

  assign addr_use = in_call || (in_cls == 3'd1) || (in_cls == 3'd2) || (in_cls == 3'd4);
  assign hazard   = addr_use && (busy(in_base, sb_cnt) || busy(in_idx, sb_cnt));
  assign freeze   = vld[3] && (ex_left != '0);
  assign issue    = in_valid && !hazard && !freeze;
  assign stall    = in_valid && !issue;

  always_comb begin
    gap = '0;
    if (!in_call) begin
      case (in_cls)
        3'd0, 3'd1: gap = (CW+1)'(GAP_ALU);
        3'd2:       gap = (CW+1)'(GAP_LD);
        3'd4, 3'd5: gap = (CW+1)'(GAP_LA);
        default:    gap = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      tag     <= '0;
      cls     <= '0;
      isc     <= '0;
      ex_left <= '0;
      sb_cnt  <= '0;
    end else begin
      for (int r = 0; r < NREG; r++)
        if (sb_cnt[r] != '0) sb_cnt[r] <= sb_cnt[r] - 1'b1;
      if (issue && gap != '0 && in_dst != '0)
        sb_cnt[in_dst] <= CW'(gap - 1'b1);

      if (freeze) begin
        ex_left <= ex_left - 1'b1;
        vld[4]  <= 1'b0;
      end else begin
        vld[0] <= issue;
        tag[0] <= in_tag;
        cls[0] <= in_cls;
        isc[0] <= in_call;
        for (int i = 1; i < NST; i++) begin
          vld[i] <= vld[i-1];
          tag[i] <= tag[i-1];
          cls[i] <= cls[i-1];
          isc[i] <= isc[i-1];
        end
        ex_left <= vld[2] ? EW'(occ(cls[2], isc[2]) - 1'b1) : '0;
      end
    end
  end

  assign stg_vld = vld;
  for (genvar g = 0; g < NST; g++) begin : g_tag
    assign stg_tag[g*TW +: TW] = tag[g];
  end
endmodule

// File: rtl/agi_issue_chk.sv
`timescale 1ns/1ps
module agi_issue_chk #(
  parameter int NREG = 16,
  parameter int TW   = 4,
  parameter int CW   = 3,
  parameter int EW   = 3,
  parameter int GMAX = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [TW-1:0]        in_tag,
  input logic                 issue,
  input logic                 stall,
  input logic [4:0]           stg_vld,
  input logic [5*TW-1:0]      stg_tag,
  input logic [EW-1:0]        ex_left,
  input logic [NREG-1:0][CW-1:0] sb_cnt
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst) !(issue && stall)); // R11
  AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) stall |-> in_valid); // R11
  AST_ISSUE_LANDS: assert property (@(posedge clk) disable iff (rst)
    issue |=> (stg_vld[0] && stg_tag[TW-1:0] == $past(in_tag))); // R2
  AST_WB_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (stg_vld[3] && ex_left == '0) |=> (stg_vld[4] && stg_tag[4*TW +: TW] == $past(stg_tag[3*TW +: TW]))); // R2
  AST_EX_HELD: assert property (@(posedge clk) disable iff (rst)
    (stg_vld[3] && ex_left != '0) |=> (stg_vld[3] && $stable(stg_tag[3*TW +: TW]) && !stg_vld[4])); // R10
  AST_FRONT_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (stg_vld[3] && ex_left != '0 && in_valid) |-> stall); // R10
  AST_REG0_EMPTY: assert property (@(posedge clk) disable iff (rst) sb_cnt[0] == '0); // R7
  for (genvar r = 1; r < NREG; r++) begin : g_cnt
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      sb_cnt[r] <= CW'(GMAX - 1)); // R3
  end
endmodule

bind agi_issue_ctrl agi_issue_chk #(.NREG(NREG), .TW(TW), .CW(CW), .EW(EW), .GMAX(GMAX)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag), .issue(issue), .stall(stall),
  .stg_vld(stg_vld), .stg_tag(stg_tag), .ex_left(ex_left), .sb_cnt(sb_cnt));

// File: tb/agi_issue_ctrl_bench.sv
`timescale 1ns/1ps
module agi_issue_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_call = 1'b0;
  logic [2:0] in_cls = '0;
  logic [3:0] in_dst = '0, in_base = '0, in_idx = '0, in_tag = '0;
  logic issue, stall;
  logic [4:0] stg_vld;
  logic [19:0] stg_tag;
  int vec = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  agi_issue_ctrl u_agi_issue_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_call(in_call),
    .in_dst(in_dst), .in_base(in_base), .in_idx(in_idx), .in_tag(in_tag),
    .issue(issue), .stall(stall), .stg_vld(stg_vld), .stg_tag(stg_tag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stag(input int i);
    return int'(stg_tag[i*4 +: 4]);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int c, input bit k, input int d, input int b, input int x,
                      input int t, output int st);
    st = 0;
    in_valid = 1'b1; in_cls = 3'(c); in_call = k;
    in_dst = 4'(d); in_base = 4'(b); in_idx = 4'(x); in_tag = 4'(t);
    #1;
    while (!issue && st < 64) begin
      st++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    int st;
    check(stg_vld == 5'b0, "R1 stages empty", int'(stg_vld), 0);
    check(!issue && !stall, "R11 quiet without request", int'({issue, stall}), 0);
    push(1, 0, 0, 3, 5, 1, st);
    check(st == 0, "R1 no stall after reset", st, 0);
    idle(10);
  endtask

  task automatic t_flow();
    int st;
    push(0, 0, 0, 0, 0, 9, st);
    for (int i = 0; i < 5; i++) begin
      check(stg_vld[i] && stag(i) == 9, "R2 stage walk", stag(i), 9);
      @(negedge clk);
    end
    idle(6);
  endtask

  task automatic t_gap(input int pc, input int cc, input int r, input bit use_idx,
                       input int exp, input string req);
    int st;
    push(pc, 0, r, 0, 0, 2, st);
    push(cc, 0, 0, use_idx ? 0 : r, use_idx ? r : 0, 11, st);
    check(st == exp, req, st, exp);
    check(stg_vld[0] && stag(0) == 11, "R11 held instruction issues", stag(0), 11);
    idle(8);
  endtask

  task automatic t_nonaddr();
    int st;
    push(0, 0, 3, 0, 0, 1, st);
    push(0, 0, 0, 3, 3, 2, st);
    check(st == 0, "R6 integer ignores base", st, 0);
    push(3, 0, 0, 3, 0, 3, st);
    check(st == 0, "R6 store ignores base", st, 0);
    push(5, 0, 0, 0, 3, 4, st);
    check(st == 0, "R6 rel-la ignores index", st, 0);
    idle(8);
    push(4, 0, 2, 0, 0, 5, st);
    push(0, 1, 0, 2, 0, 6, st);
    check(st == 1, "R6 call forms address", st, 1);
    idle(14);
  endtask

  task automatic t_reg0();
    int st;
    push(0, 0, 0, 0, 0, 1, st);
    push(1, 0, 0, 0, 0, 2, st);
    check(st == 0, "R7 register zero free", st, 0);
    idle(8);
  endtask

  task automatic t_noprod();
    int st;
    push(3, 0, 4, 0, 0, 1, st);
    push(1, 0, 0, 4, 0, 2, st);
    check(st == 0, "R8 store no entry", st, 0);
    idle(8);
    push(6, 0, 4, 0, 0, 3, st);
    push(2, 0, 0, 0, 4, 4, st);
    check(st == 0, "R8 two-cycle op no entry", st, 0);
    idle(10);
    push(0, 1, 4, 0, 0, 5, st);
    push(4, 0, 0, 4, 0, 6, st);
    check(st == 0, "R8 call no entry", st, 0);
    idle(14);
  endtask

  task automatic t_latest();
    int st;
    push(0, 0, 8, 0, 0, 1, st);
    push(4, 0, 8, 0, 0, 2, st);
    push(1, 0, 0, 8, 0, 3, st);
    check(st == 1, "R9 shorter latest gap", st, 1);
    idle(8);
    push(4, 0, 9, 0, 0, 1, st);
    push(0, 0, 9, 0, 0, 2, st);
    push(1, 0, 0, 9, 0, 3, st);
    check(st == 4, "R9 longer latest gap", st, 4);
    idle(8);
  endtask

  task automatic t_exec(input int c, input bit k, input int occ, input string req);
    int st;
    push(c, k, 0, 0, 0, 13, st);
    idle(occ + 2);
    check(stg_vld[3] && stag(3) == 13 && !stg_vld[4], {req, " execute held, bubble"}, stag(3), 13);
    @(negedge clk);
    check(stg_vld[4] && stag(4) == 13, {req, " reaches write-back"}, stag(4), 13);
    idle(8);
    push(c, k, 0, 0, 0, 13, st);
    push(0, 0, 0, 0, 0, 1, st);
    push(0, 0, 0, 0, 0, 2, st);
    push(0, 0, 0, 0, 0, 3, st);
    push(0, 0, 0, 0, 0, 4, st);
    check(st == occ - 1, {req, " decode stalls"}, st, occ - 1);
    idle(14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_flow();
    t_gap(0, 1, 3, 0, 4, "R3 integer to memory base");
    t_gap(1, 2, 5, 1, 4, "R3 memory to load index");
    t_gap(2, 4, 5, 0, 2, "R4 load to load-address");
    t_gap(4, 1, 6, 0, 1, "R5 load-address to memory");
    t_gap(5, 2, 7, 1, 1, "R5 rel-la to load index");
    t_nonaddr();
    t_reg0();
    t_noprod();
    t_latest();
    t_exec(6, 0, 2, "R10 two-cycle");
    t_exec(7, 0, 3, "R10 three-cycle");
    t_exec(0, 1, 5, "R10 call");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(stg_vld == 5'b0, "R1 reset mid-run", int'(stg_vld), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #(20 * 150000);
    join_any
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule